// File: doc/BRIEF.md
# Load/Store Instruction Pipeline with Store Buffer

The block moves memory instructions through an in-order pipeline. An instruction is either a load that carries a latency or a store that carries none. Each accepted instruction first sits in a pre stage. It then moves into a shared load/store stage. From there it splits by opcode: a load goes to the load unit and a store goes to the store unit. From either unit it retires to a done stage, which is reported as a one-cycle pulse.

The shared stage, the load unit and the store unit each hold at most one instruction. The load unit counts down the load's remaining latency. A store that leaves the store unit is written into a small store buffer. Downstream logic empties that buffer one entry at a time through a drain handshake. The buffer reports three states, and the bus is reported free only when the buffer is empty and the store unit is idle. When a unit is busy, the instructions behind it stall in place, and back-pressure reaches the issue port.

Top module: `mem_pipe`

## Requirements
- R1: While `rst_ni` is low, all four busy flags are low, `lu_cnt_o` is 0, `sb_state_o` is 0 (empty), `drain_valid_o` is low, `bus_free_o` is high and `issue_ready_o` is high.
- R2: An instruction is accepted into the pre stage in a cycle where `issue_valid_i` and `issue_ready_o` are both high. `pre_busy_o` is high in the following cycle.
- R3: While the load/store stage is occupied, `ls_route_o` gives the stage its occupant goes to next: 2 for a load (load unit) and 3 for a store (store unit). When that stage is empty, `ls_route_o` is 0.
- R4: The occupant of the load/store stage advances only when its target unit is empty or is releasing its instruction in the same cycle. Otherwise it stays in place. The pre stage advances only when the load/store stage is free or advancing. `issue_ready_o` is high only when the pre stage is empty or advancing.
- R5: A load that enters the load unit loads its latency L into `lu_cnt_o`. The count drops by one each cycle. When the count is 0 the load leaves, with `done_load_o` high for that cycle. A load therefore stays in the load unit for L+1 cycles.
- R6: `lu_cnt_o` is 0 whenever the load unit is empty. A store always carries a count of 0.
- R7: A store leaves the store unit, with `done_store_o` high for that cycle, when the store buffer is not full or is being drained in the same cycle. In that cycle it writes one entry into the buffer.
- R8: `sb_state_o` follows the buffer occupancy: 0 for empty, 1 for partly filled, 2 for full (SB_DEPTH entries). `drain_valid_o` is high when the buffer is not empty. Each cycle in which `drain_valid_o` and `drain_ready_i` are both high removes one entry.
- R9: `bus_free_o` is high exactly when the store buffer is empty and the store unit is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | Instruction offered |
| issue_store_i | input | 1 | 1 = store, 0 = load |
| issue_lat_i | input | LAT_W | Load latency, ignored for stores |
| issue_ready_o | output | 1 | Pre stage can accept |
| drain_ready_i | input | 1 | Downstream takes one buffer entry |
| drain_valid_o | output | 1 | Store buffer holds an entry |
| pre_busy_o | output | 1 | Pre stage occupied |
| ls_busy_o | output | 1 | Load/store stage occupied |
| lu_busy_o | output | 1 | Load unit occupied |
| su_busy_o | output | 1 | Store unit occupied |
| ls_route_o | output | 3 | Next-stage code of the load/store occupant |
| lu_cnt_o | output | LAT_W | Remaining load-unit cycles |
| sb_state_o | output | 2 | Store buffer state code |
| done_load_o | output | 1 | A load retires this cycle |
| done_store_o | output | 1 | A store retires this cycle |
| bus_free_o | output | 1 | Bus available |

## Verification
The bench targets three stall situations. The first is a long-latency load that makes the next load wait in the shared stage: a design that ignores the target unit's occupancy would overwrite the load in flight and lose a done pulse. The second is a store stream with the drain held off: the buffer must stop at full and hold the store unit. A design that pushes into a full buffer would report an extra done pulse or wrap its state back to empty, and it would raise the bus-free flag too early. The third is zero-latency loads and the same-cycle handover between stages: an off-by-one counter, or a unit that does not free up in the cycle its occupant leaves, shows up as shifted done pulses and reduced throughput compared with the reference model.

// File: rtl/mem_pipe_pkg.sv
package mem_pipe_pkg;

  typedef enum logic [2:0] {
    STG_PRE  = 3'd0,
    STG_LS   = 3'd1,
    STG_LU   = 3'd2,
    STG_SU   = 3'd3,
    STG_DONE = 3'd4
  } stg_e;

  typedef enum logic [1:0] {
    SB_EMPTY = 2'd0,
    SB_PART  = 2'd1,
    SB_FULL  = 2'd2
  } sb_e;

  // stage successor; the shared stage forks on opcode
  function automatic stg_e stg_next(input stg_e s, input logic is_store);
    case (s)
      STG_PRE: stg_next = STG_LS;
      STG_LS:  stg_next = is_store ? STG_SU : STG_LU;
      default: stg_next = STG_DONE;
    endcase
  endfunction

endpackage

// File: rtl/mem_pipe_front.sv
module mem_pipe_front #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             issue_store_i,
  input  logic [LAT_W-1:0] issue_lat_i,
  output logic             issue_ready_o,
  input  logic             ls_adv_i,
  output logic             pre_v_o,
  output logic             ls_v_o,
  output logic             ls_store_o,
  output logic [LAT_W-1:0] ls_lat_o
);

  logic             pre_v, pre_st;
  logic [LAT_W-1:0] pre_lat;
  logic             ls_v, ls_st;
  logic [LAT_W-1:0] ls_lat;
  logic             ls_take;

  assign ls_take       = !ls_v || ls_adv_i;
  assign issue_ready_o = !pre_v || ls_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_v   <= 1'b0;
      pre_st  <= 1'b0;
      pre_lat <= '0;
    end else if (issue_ready_o) begin
      pre_v   <= issue_valid_i;
      pre_st  <= issue_store_i;
      pre_lat <= issue_store_i ? '0 : issue_lat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_v   <= 1'b0;
      ls_st  <= 1'b0;
      ls_lat <= '0;
    end else if (ls_take) begin
      ls_v   <= pre_v;
      ls_st  <= pre_st;
      ls_lat <= pre_lat;
    end
  end

  assign pre_v_o    = pre_v;
  assign ls_v_o     = ls_v;
  assign ls_store_o = ls_st;
  assign ls_lat_o   = ls_lat;

endmodule

// File: rtl/mem_pipe_lu.sv
module mem_pipe_lu #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [LAT_W-1:0] in_lat_i,
  output logic             busy_o,
  output logic             free_o,
  output logic             leave_o,
  output logic [LAT_W-1:0] cnt_o
);

  logic             busy;
  logic [LAT_W-1:0] cnt;

  assign leave_o = busy && (cnt == '0);
  assign free_o  = !busy || leave_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (in_valid_i) begin
      busy <= 1'b1;
      cnt  <= in_lat_i;
    end else if (leave_o) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

  assign busy_o = busy;
  assign cnt_o  = cnt;

endmodule

// File: rtl/mem_pipe_sbuf.sv
module mem_pipe_sbuf
  import mem_pipe_pkg::*;
#(
  parameter int SB_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic drain_ready_i,
  output logic drain_valid_o,
  output logic busy_o,
  output logic free_o,
  output logic leave_o,
  output sb_e  state_o
);

  localparam int CNT_W = $clog2(SB_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SB_DEPTH);

  logic             su_v;
  logic [CNT_W-1:0] cnt;
  logic             pop;

  assign drain_valid_o = (cnt != '0);
  assign pop           = drain_valid_o && drain_ready_i;
  assign leave_o       = su_v && ((cnt != FULL_CNT) || pop);
  assign free_o        = !su_v || leave_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) su_v <= 1'b0;
    else if (in_valid_i) su_v <= 1'b1;
    else if (leave_o) su_v <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (leave_o && !pop) cnt <= cnt + 1'b1;
    else if (!leave_o && pop) cnt <= cnt - 1'b1;
  end

  always_comb begin
    if (cnt == '0)           state_o = SB_EMPTY;
    else if (cnt == FULL_CNT) state_o = SB_FULL;
    else                     state_o = SB_PART;
  end

  assign busy_o = su_v;

endmodule

// File: rtl/mem_pipe.sv
module mem_pipe
  import mem_pipe_pkg::*;
#(
  parameter int LAT_W    = 4,
  parameter int SB_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             issue_store_i,
  input  logic [LAT_W-1:0] issue_lat_i,
  output logic             issue_ready_o,
  input  logic             drain_ready_i,
  output logic             drain_valid_o,
  output logic             pre_busy_o,
  output logic             ls_busy_o,
  output logic             lu_busy_o,
  output logic             su_busy_o,
  output logic [2:0]       ls_route_o,
  output logic [LAT_W-1:0] lu_cnt_o,
  output logic [1:0]       sb_state_o,
  output logic             done_load_o,
  output logic             done_store_o,
  output logic             bus_free_o
);

  logic             ls_v, ls_st;
  logic [LAT_W-1:0] ls_lat;
  logic             lu_free, su_free;
  logic             to_lu, to_su;
  stg_e             route;
  sb_e              sb_state;

  assign route = ls_v ? stg_next(STG_LS, ls_st) : STG_PRE;
  assign to_lu = (route == STG_LU) && lu_free;
  assign to_su = (route == STG_SU) && su_free;

  mem_pipe_front #(.LAT_W(LAT_W)) u_front (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_valid_i(issue_valid_i),
    .issue_store_i(issue_store_i),
    .issue_lat_i  (issue_lat_i),
    .issue_ready_o(issue_ready_o),
    .ls_adv_i     (to_lu || to_su),
    .pre_v_o      (pre_busy_o),
    .ls_v_o       (ls_v),
    .ls_store_o   (ls_st),
    .ls_lat_o     (ls_lat)
  );

  mem_pipe_lu #(.LAT_W(LAT_W)) u_lu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(to_lu),
    .in_lat_i  (ls_lat),
    .busy_o    (lu_busy_o),
    .free_o    (lu_free),
    .leave_o   (done_load_o),
    .cnt_o     (lu_cnt_o)
  );

  mem_pipe_sbuf #(.SB_DEPTH(SB_DEPTH)) u_sbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (to_su),
    .drain_ready_i(drain_ready_i),
    .drain_valid_o(drain_valid_o),
    .busy_o       (su_busy_o),
    .free_o       (su_free),
    .leave_o      (done_store_o),
    .state_o      (sb_state)
  );

  assign ls_busy_o  = ls_v;
  assign ls_route_o = route;
  assign sb_state_o = sb_state;
  assign bus_free_o = (sb_state == SB_EMPTY) && !su_busy_o;

endmodule

// File: rtl/mem_pipe_chk.sv
module mem_pipe_chk #(
  parameter int LAT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic             drain_ready_i,
  input logic             drain_valid_o,
  input logic             pre_busy_o,
  input logic             ls_busy_o,
  input logic             lu_busy_o,
  input logic             su_busy_o,
  input logic [2:0]       ls_route_o,
  input logic [LAT_W-1:0] lu_cnt_o,
  input logic [1:0]       sb_state_o,
  input logic             done_store_o,
  input logic             bus_free_o
);

  p_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && issue_ready_o |=> pre_busy_o);

  p_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_busy_o && ls_busy_o && ls_route_o == 3'd2 && lu_busy_o && lu_cnt_o != '0
    |=> pre_busy_o && ls_busy_o && ls_route_o == 3'd2);

  p_lu_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_busy_o && lu_cnt_o != '0 |=> lu_busy_o && lu_cnt_o == $past(lu_cnt_o) - 1'b1);

  p_cnt_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lu_busy_o |-> lu_cnt_o == '0);

  p_su_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    su_busy_o && sb_state_o == 2'd2 && !drain_ready_i |=> su_busy_o && sb_state_o == 2'd2);

  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_state_o == 2'd2 && drain_valid_o && drain_ready_i && !done_store_o |=> sb_state_o == 2'd1);

  p_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_free_o |-> !su_busy_o && sb_state_o == 2'd0 && !drain_valid_o);

endmodule

bind mem_pipe mem_pipe_chk #(.LAT_W(LAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .drain_ready_i(drain_ready_i),
  .drain_valid_o(drain_valid_o),
  .pre_busy_o   (pre_busy_o),
  .ls_busy_o    (ls_busy_o),
  .lu_busy_o    (lu_busy_o),
  .su_busy_o    (su_busy_o),
  .ls_route_o   (ls_route_o),
  .lu_cnt_o     (lu_cnt_o),
  .sb_state_o   (sb_state_o),
  .done_store_o (done_store_o),
  .bus_free_o   (bus_free_o)
);

// File: tb/mem_pipe_tb.sv
`timescale 1ns/1ps
module mem_pipe_tb;
  localparam int LAT_W = 4;
  localparam int DEPTH = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic iv = 1'b0, ist = 1'b0, dr = 1'b0;
  logic [LAT_W-1:0] ilat = '0;
  logic rdy, dvalid, pre_b, ls_b, lu_b, su_b, dl, ds, bfree;
  logic [2:0] route;
  logic [LAT_W-1:0] lcnt;
  logic [1:0] sbs;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int unsigned rng = 32'h1234_5678;

  // reference state
  int m_pre_v = 0, m_pre_st = 0, m_pre_lat = 0;
  int m_ls_v = 0, m_ls_st = 0, m_ls_lat = 0;
  int m_lu_v = 0, m_lu_c = 0, m_su_v = 0;
  int sbq[$];

  always #2.5 clk_i = ~clk_i;

  mem_pipe #(.LAT_W(LAT_W), .SB_DEPTH(DEPTH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_i(iv), .issue_store_i(ist),
    .issue_lat_i(ilat), .issue_ready_o(rdy), .drain_ready_i(dr), .drain_valid_o(dvalid),
    .pre_busy_o(pre_b), .ls_busy_o(ls_b), .lu_busy_o(lu_b), .su_busy_o(su_b),
    .ls_route_o(route), .lu_cnt_o(lcnt), .sb_state_o(sbs), .done_load_o(dl),
    .done_store_o(ds), .bus_free_o(bfree)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic step(input int v, input int s, input int l, input int d);
    int pop, sugo, lugo, lsgo, prdy, sbn, st;
    @(negedge clk_i);
    iv = v[0]; ist = s[0]; ilat = LAT_W'(l); dr = d[0];
    #1;
    sbn  = sbq.size();
    pop  = (sbn > 0 && d != 0) ? 1 : 0;
    sugo = (m_su_v != 0 && (sbn < DEPTH || pop != 0)) ? 1 : 0;
    lugo = (m_lu_v != 0 && m_lu_c == 0) ? 1 : 0;
    lsgo = 0;
    if (m_ls_v != 0)
      lsgo = m_ls_st != 0 ? (m_su_v == 0 || sugo != 0) : (m_lu_v == 0 || lugo != 0);
    prdy = (m_pre_v == 0 || m_ls_v == 0 || lsgo != 0) ? 1 : 0;
    st   = sbn == 0 ? 0 : (sbn == DEPTH ? 2 : 1);
    chk("R2 ready", rdy, prdy);
    chk("R2 pre_busy", pre_b, m_pre_v);
    chk("R4 ls_busy", ls_b, m_ls_v);
    chk("R3 route", route, m_ls_v == 0 ? 0 : (m_ls_st != 0 ? 3 : 2));
    chk("R5 lu_busy", lu_b, m_lu_v);
    chk("R6 lu_cnt", lcnt, m_lu_v != 0 ? m_lu_c : 0);
    chk("R5 done_load", dl, lugo);
    chk("R7 su_busy", su_b, m_su_v);
    chk("R7 done_store", ds, sugo);
    chk("R8 sb_state", sbs, st);
    chk("R8 drain_valid", dvalid, sbn > 0 ? 1 : 0);
    chk("R9 bus_free", bfree, (sbn == 0 && m_su_v == 0) ? 1 : 0);
    @(posedge clk_i);
    cyc++;
    if (pop != 0) void'(sbq.pop_front());
    if (sugo != 0) sbq.push_back(1);
    if (lsgo != 0 && m_ls_st != 0) m_su_v = 1;
    else if (sugo != 0) m_su_v = 0;
    if (lsgo != 0 && m_ls_st == 0) begin m_lu_v = 1; m_lu_c = m_ls_lat; end
    else if (lugo != 0) m_lu_v = 0;
    else if (m_lu_v != 0) m_lu_c--;
    if (m_ls_v == 0 || lsgo != 0) begin
      m_ls_v = m_pre_v; m_ls_st = m_pre_st; m_ls_lat = m_pre_lat;
    end
    if (prdy != 0) begin
      m_pre_v = v; m_pre_st = s; m_pre_lat = s != 0 ? 0 : l;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values while held low
    chk("R1 ready", rdy, 1);
    chk("R1 busy", {pre_b, ls_b, lu_b, su_b}, 0);
    chk("R1 lu_cnt", lcnt, 0);
    chk("R1 sb_state", sbs, 0);
    chk("R1 drain_valid", dvalid, 0);
    chk("R1 bus_free", bfree, 1);
    rst_ni = 1'b1;
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int unsigned r = nxt();
      step(int'(r[0]), int'(r[1]), int'(r[7:4]), int'(r[9:8] != 0));
    end
    // R4/R5: long loads back to back stall in shared stage
    for (int i = 0; i < 150; i++) step(1, 0, 15, 1);
    // R7/R8: stores with drain off fill the buffer
    for (int i = 0; i < 60; i++) step(1, 1, 9, 0);
    // R8: drain with no issue
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1);
    // R5: zero-latency loads
    for (int i = 0; i < 100; i++) step(1, 0, 0, 1);
    // alternating opcodes with sparse drain
    for (int i = 0; i < 200; i++) begin
      int unsigned r = nxt();
      step(1, i % 2, int'(r[1:0]), int'(r[3:2] == 0));
    end
    for (int i = 0; i < 400; i++) begin
      int unsigned r = nxt();
      step(int'(r[2:0] != 0), int'(r[3]), int'(r[5:4]), int'(r[6]));
    end
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule